// File: doc/BRIEF.md
# Serial EEPROM Read Target

This block is the read side of a two-wire serial memory. It watches SCL and SDA, finds START, repeated START and STOP conditions, and answers when the first byte after a START carries its 7-bit device address. The memory is a byte array of 128 to 2048 locations, set to a fixed fill pattern at reset. Writes into the array are outside this block. A write-direction transfer is used only to load the internal byte address.

A single address counter serves all three kinds of read. A current-address read starts sending at once from the counter. A random read first loads the counter through a dummy write and then reads after a repeated START. A sequential read continues for as long as the master acknowledges. The counter keeps its value from one transaction to the next. By default it wraps from the last location to zero. An optional mode, meant for the smallest size, holds it at the last location instead. SDA is driven as an open-drain enable: `sda_oe` high pulls the line low.

SCL and SDA are synchronised to the fast system clock before any edge detection. The block reads SDA on rising SCL and changes its own drive only after SCL falls.

Top module: `eeprom_read_target`

## Requirements
- R1: While `rst` is high and after it falls, `sda_oe` is 0 and the address counter is 0. Location a holds the low 8 bits of 29*a + 7*(a>>8) + 83.
- R2: SDA is sampled on the rising edge of SCL. `sda_oe` changes only in response to a falling SCL edge or to a START or STOP, so it never changes while SCL stays high between those events.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one aborts any transfer in progress and releases SDA. The address counter keeps its last value.
- R4: The first byte after a START is sent MSB first. Bits 7:1 are the device address and bit 0 is the direction (1 = read). On a match the block pulls SDA low for the 9th clock.
- R5: On an address mismatch the block does not acknowledge. It keeps SDA released for every later clock until the next START.
- R6: A read-direction address causes the block to acknowledge and then send, MSB first, the byte at the counter, with no byte-address phase.
- R7: A write-direction address followed by one byte is a dummy write. Both bytes are acknowledged, and the byte loads the counter. After a repeated START, a read returns the byte at the loaded address.
- R8: For memories of 256 bytes or fewer, byte-address bits above the memory size are ignored. For larger memories, device-address bits 2:0 supply counter bits 10:8 during a dummy write and do not take part in the address match.
- R9: A master acknowledge (SDA low on the 9th clock of a sent byte) causes the next byte to follow. A NoACK stops the sending and releases SDA until the next START.
- R10: The counter advances by one after each fully sent byte and persists across transactions. A byte aborted before its 8th bit does not advance it.
- R11: At the last location the counter wraps to 0. With the no-wrap option set, it holds at the last location, so that byte repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that each SCL level lasts several system clocks longer than the synchroniser delay. They also assume that the master moves SDA only while SCL is low, except to form START and STOP, and that the memory size is a power of two. The stimulus holds each SCL half-period for ten system clocks and changes master data five clocks into the low phase. Every START and STOP the bench issues falls on a point where the target has already released SDA, so an abort never has to fight a low data bit. Three instances share one wired-AND bus, each with its own address, size and wrap mode, so each instance also sees traffic addressed to the others.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_DEV_ACK,
        PH_WADR,
        PH_WADR_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic [7:0] fill_byte(input int unsigned a);
        return 8'(a * 29 + (a >> 8) * 7 + 83);
    endfunction

endpackage

// File: rtl/eeprom_bus_sampler.sv
module eeprom_bus_sampler
    import eeprom_rd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/eeprom_byte_store.sv
module eeprom_byte_store
    import eeprom_rd_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter bit NO_WRAP   = 1'b0,
    localparam int AW       = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          advance,
    output logic [7:0]    rd_data,
    output logic [AW-1:0] cur_addr
);
    localparam logic [AW-1:0] LAST = AW'(MEM_BYTES - 1);

    logic [7:0]    cells [MEM_BYTES];
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_next;

    generate
        if (NO_WRAP) begin : g_hold_end
            assign ptr_next = (ptr_q == LAST) ? ptr_q : ptr_q + 1'b1;
        end else begin : g_wrap_end
            assign ptr_next = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                cells[i] <= fill_byte(i);
            end
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_addr;
        end else if (advance) begin
            ptr_q <= ptr_next;
        end
    end

    assign rd_data  = cells[ptr_q];
    assign cur_addr = ptr_q;
endmodule

// File: rtl/eeprom_read_target.sv
module eeprom_read_target
    import eeprom_rd_pkg::*;
#(
    parameter int         MEM_BYTES   = 256,
    parameter logic [6:0] DEV_ID      = 7'h50,
    parameter bit         NO_WRAP     = 1'b0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int         AW         = $clog2(MEM_BYTES);
    localparam int         BLK        = (AW > 8) ? AW - 8 : 0;
    localparam logic [6:0] MATCH_MASK = 7'(7'h7F << BLK);

    bus_ev_t       ev;
    phase_e        phase;
    logic [2:0]    bitcnt;
    logic [7:0]    shreg;
    logic          byte_done;
    logic          rd_mode;
    logic          mack;
    logic          oe_q;
    logic [2:0]    blk_q;
    logic          quiet;
    logic          dev_hit;
    logic          addr_load;
    logic          addr_adv;
    logic [10:0]   wide_addr;
    logic [AW-1:0] load_addr;
    logic [AW-1:0] cur_addr;
    logic [7:0]    rd_data;

    eeprom_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign quiet     = !ev.start && !ev.stop;
    assign dev_hit   = ((shreg[7:1] ^ DEV_ID) & MATCH_MASK) == 7'd0;
    assign wide_addr = {blk_q, shreg};
    assign load_addr = wide_addr[AW-1:0];
    assign addr_load = quiet && (phase == PH_WADR) && ev.scl_fall && byte_done;
    assign addr_adv  = quiet && (phase == PH_TX) && ev.scl_fall && (bitcnt == 3'd7);

    eeprom_byte_store #(.MEM_BYTES(MEM_BYTES), .NO_WRAP(NO_WRAP)) u_store (
        .clk       (clk),
        .rst       (rst),
        .load      (addr_load),
        .load_addr (load_addr),
        .advance   (addr_adv),
        .rd_data   (rd_data),
        .cur_addr  (cur_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            rd_mode   <= 1'b0;
            mack      <= 1'b0;
            oe_q      <= 1'b0;
            blk_q     <= '0;
        end else if (ev.stop) begin
            phase     <= PH_IDLE;
            oe_q      <= 1'b0;
            byte_done <= 1'b0;
        end else if (ev.start) begin
            phase     <= PH_DEV;
            bitcnt    <= '0;
            oe_q      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            unique case (phase)
                PH_DEV, PH_WADR: begin
                    if (ev.scl_rise && !byte_done) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) byte_done <= 1'b1;
                    end else if (ev.scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        bitcnt    <= '0;
                        if (phase == PH_WADR) begin
                            oe_q  <= 1'b1;
                            phase <= PH_WADR_ACK;
                        end else if (dev_hit) begin
                            oe_q    <= 1'b1;
                            rd_mode <= shreg[0];
                            blk_q   <= shreg[3:1];
                            phase   <= PH_DEV_ACK;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                PH_DEV_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            shreg <= rd_data;
                            oe_q  <= ~rd_data[7];
                            phase <= PH_TX;
                        end else begin
                            oe_q  <= 1'b0;
                            phase <= PH_WADR;
                        end
                    end
                end
                PH_WADR_ACK: begin
                    if (ev.scl_fall) begin
                        oe_q  <= 1'b0;
                        phase <= PH_IDLE;
                    end
                end
                PH_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            oe_q      <= 1'b0;
                            byte_done <= 1'b0;
                            phase     <= PH_MACK;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            shreg  <= {shreg[6:0], 1'b0};
                            oe_q   <= ~shreg[6];
                        end
                    end
                end
                PH_MACK: begin
                    if (ev.scl_rise) begin
                        mack      <= ~ev.sda;
                        byte_done <= 1'b1;
                    end else if (ev.scl_fall && byte_done) begin
                        byte_done <= 1'b0;
                        if (mack) begin
                            shreg  <= rd_data;
                            oe_q   <= ~rd_data[7];
                            bitcnt <= '0;
                            phase  <= PH_TX;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign sda_oe = oe_q;
endmodule

// File: rtl/eeprom_read_target_chk.sv
module eeprom_read_target_chk #(
    parameter int AW      = 8,
    parameter bit NO_WRAP = 1'b0
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_fall,
    input logic          bus_start,
    input logic          bus_stop,
    input logic          sda_oe,
    input logic          load,
    input logic          advance,
    input logic [AW-1:0] cur_addr
);
    localparam logic [AW-1:0] LAST = '1;

    AST_OE_AFTER_EVENT: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(scl_fall || bus_start || bus_stop)); // R2

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !sda_oe); // R3

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> !sda_oe); // R3

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && cur_addr != LAST) |=> cur_addr == $past(cur_addr) + 1'b1); // R10

    AST_PTR_END: assert property (@(posedge clk) disable iff (rst)
        (advance && cur_addr == LAST) |=> cur_addr == (NO_WRAP ? LAST : '0)); // R11

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!advance && !load) |=> $stable(cur_addr)); // R10

    AST_LOAD_ALONE: assert property (@(posedge clk) disable iff (rst)
        !(load && advance)); // R7
endmodule

bind eeprom_read_target eeprom_read_target_chk #(.AW(AW), .NO_WRAP(NO_WRAP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_fall  (ev.scl_fall),
    .bus_start (ev.start),
    .bus_stop  (ev.stop),
    .sda_oe    (sda_oe),
    .load      (addr_load),
    .advance   (addr_adv),
    .cur_addr  (cur_addr)
);

// File: tb/tb_eeprom_read_target.sv
module tb_eeprom_read_target;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic oe_a, oe_b, oe_c;
    logic bus_sda;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    int ptr [3];
    int size [3] = '{256, 128, 2048};
    bit nowrap [3] = '{1'b0, 1'b1, 1'b0};

    always #5 clk = ~clk;

    assign bus_sda = m_sda & ~oe_a & ~oe_b & ~oe_c;

    eeprom_read_target #(.MEM_BYTES(256), .DEV_ID(7'h50), .NO_WRAP(1'b0)) dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(oe_a));
    eeprom_read_target #(.MEM_BYTES(128), .DEV_ID(7'h51), .NO_WRAP(1'b1)) dut_small (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(oe_b));
    eeprom_read_target #(.MEM_BYTES(2048), .DEV_ID(7'h58), .NO_WRAP(1'b0)) dut_big (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe(oe_c));

    function automatic int fill(int a);
        return (29 * a + 7 * (a >> 8) + 83) & 255;
    endfunction

    function automatic int step(int d, int a);
        if (a == size[d] - 1) return nowrap[d] ? a : 0;
        return a + 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2: target drive must not move while SCL is high
    logic [2:0] oe_prev = 3'b000;
    always @(negedge clk) begin
        if (!rst && ({oe_a, oe_b, oe_c} != oe_prev)) begin
            check(!m_scl, "R2 drive changed with SCL high", {oe_a, oe_b, oe_c}, oe_prev);
        end
        oe_prev = {oe_a, oe_b, oe_c};
    end

    task automatic hp();
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hp();
        m_scl = 1'b1; hp(); hp();
        m_sda = 1'b0; hp(); hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hp();
        m_scl = 1'b1; hp(); hp();
        m_sda = 1'b1; hp(); hp();
    endtask

    task automatic put_bit(input logic b);
        hp(); m_sda = b; hp();
        m_scl = 1'b1; hp(); hp();
        m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        hp(); m_sda = 1'b1; hp();
        m_scl = 1'b1; hp();
        b = bus_sda; hp();
        m_scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output bit ackd);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ackd = !b;
    endtask

    task automatic get_byte(output logic [7:0] v, input bit give_ack);
        logic b;
        v = '0;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(give_ack ? 1'b0 : 1'b1);
    endtask

    // read n bytes from the counter of device d, then STOP
    task automatic rd_seq(int d, logic [6:0] dev, int n, string req);
        bit ackd;
        logic [7:0] v;
        bus_start();
        put_byte({dev, 1'b1}, ackd);
        check(ackd, {req, " R4 read address ack"}, ackd, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(v, k < n - 1);
            check(v == 8'(fill(ptr[d])), {req, " data byte"}, v, fill(ptr[d]));
            ptr[d] = step(d, ptr[d]);
        end
        bus_stop();
    endtask

    // dummy write that loads the counter, no STOP
    task automatic set_addr(int d, logic [6:0] dev, logic [7:0] wa, string req);
        bit ackd;
        bus_start();
        put_byte({dev, 1'b0}, ackd);
        check(ackd, {req, " R4 write address ack"}, ackd, 1);
        put_byte(wa, ackd);
        check(ackd, {req, " R7 byte address ack"}, ackd, 1);
        if (size[d] <= 256) ptr[d] = wa & (size[d] - 1);
        else ptr[d] = ((int'(dev & 7'h7) << 8) | wa) & (size[d] - 1);
    endtask

    initial begin
        bit ackd;
        logic b;
        logic [7:0] top2;
        for (int d = 0; d < 3; d++) ptr[d] = 0;
        repeat (10) @(negedge clk);
        check({oe_a, oe_b, oe_c} == 3'b000, "R1 drive in reset", {oe_a, oe_b, oe_c}, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check({oe_a, oe_b, oe_c} == 3'b000, "R1 drive after reset", {oe_a, oe_b, oe_c}, 0);

        // R1 R6: current-address read right after reset comes from location 0
        rd_seq(0, 7'h50, 1, "R6");

        // R7: random read
        set_addr(0, 7'h50, 8'h40, "R7");
        rd_seq(0, 7'h50, 1, "R7");

        // R10 R9: counter persists, master ack continues
        rd_seq(0, 7'h50, 3, "R10");

        // R11: wrap through the end of a 256-byte array
        set_addr(0, 7'h50, 8'hFD, "R11");
        rd_seq(0, 7'h50, 5, "R11");

        // R5: no device at this address
        bus_start();
        put_byte({7'h33, 1'b1}, ackd);
        check(!ackd, "R5 no ack", ackd, 0);
        for (int k = 0; k < 9; k++) begin
            get_bit(b);
            check(b == 1'b1, "R5 bus left released", b, 1);
        end
        bus_stop();

        // R3 R10: abort after two data bits; location 0x10 is 0x23 (bit5 = 1)
        set_addr(0, 7'h50, 8'h10, "R3");
        bus_start();
        put_byte({7'h50, 1'b1}, ackd);
        check(ackd, "R3 ack", ackd, 1);
        top2 = '0;
        get_bit(b); top2[1] = b;
        get_bit(b); top2[0] = b;
        check(top2[1:0] == 2'(fill(16) >> 6), "R3 partial bits", top2, fill(16) >> 6);
        bus_stop();
        check(oe_a == 1'b0, "R3 released after STOP", oe_a, 0);
        rd_seq(0, 7'h50, 1, "R10 aborted byte not counted");

        // R8: 128-byte device ignores byte-address bit 7
        set_addr(1, 7'h51, 8'h85, "R8");
        rd_seq(1, 7'h51, 1, "R8 small");

        // R11: no-wrap device holds at its last location
        set_addr(1, 7'h51, 8'h7E, "R11");
        rd_seq(1, 7'h51, 4, "R11 hold");

        // R8: 2048-byte device takes counter bits 10:8 from the device address
        set_addr(2, 7'h5D, 8'h20, "R8");
        rd_seq(2, 7'h5A, 2, "R8 big");

        // R11: wrap through the end of a 2048-byte array
        set_addr(2, 7'h5F, 8'hFE, "R11");
        rd_seq(2, 7'h5F, 3, "R11 big wrap");

        // R10 R5: the first device kept its counter through foreign traffic
        rd_seq(0, 7'h50, 2, "R10 persist");

        repeat (20) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule